// File: doc/BRIEF.md
# Transmit Frame Continuation Checker

This block decides, character by character, whether a transmit frame may run on past the bytes that were in the FIFO when it started, or whether it must close once the FIFO has drained. It holds an "accept" flag that tells the serializer to keep fetching bytes. The flag is set when a transmit starts. After that, only a FIFO-empty test can clear it, and that test is made at one bit position in each character. The serializer reports every bit it sends with a strobe and the bit's 1-based position within the character.

The test position is one bit before the last bit of the character, so it depends on the character format. If software writes a byte into the FIFO before the test, the FIFO does not read as empty, the flag stays set and that byte goes out in the same frame. If the FIFO is empty at the test, the flag clears at once. When the last bit of that character has been sent, a single-cycle end-of-frame pulse follows.

The control is a four-state machine:
- IDLE goes to RUN on start.
- RUN goes to DRAIN when the FIFO is empty at the test position.
- RUN goes straight to DONE when the test position is also the last bit.
- DRAIN goes to DONE on the strobe of the last bit.
- DONE goes back to IDLE after one cycle.
- Abort sends every state to IDLE.

Top module: `txc_frame_cont`

## Requirements
- R1: `start` in IDLE raises `accept` on the next clock edge. `start` has no effect in RUN, DRAIN or DONE.
- R2: `fifo_empty` seen on a strobe whose `bit_idx` is not the test position leaves `accept` unchanged. `accept` falls only on an empty test or on abort.
- R3: Format code 0 (8 data bits plus parity) tests at bit 8, and its last bit is 9. Code 3 behaves the same as code 0.
- R4: Format code 1 (8 bits, no parity) tests at bit 7, and its last bit is 8.
- R5: Format code 2 (x bits, no parity) tests at bit x-1, and its last bit is x, for x from 2 to 8.
- R6: In format code 2, x=1 tests at bit 1, which is also the last bit, so `eof` follows directly. `part_bits` values of 0 are treated as 1, and values above 8 are treated as 8.
- R7: A FIFO that is not empty at the test keeps `accept` high, so a frame continues for any number of characters.
- R8: A FIFO that is empty at the test drops `accept` on that edge. `eof` is high for exactly one cycle, starting at the edge after the strobe of the character's last bit.
- R9: `abort` returns the block to IDLE on the next edge with `accept` low and no `eof`. It wins over `start` in the same cycle.
- R10: While reset is active, `accept` and `eof` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transmit start pulse |
| abort | input | 1 | Cancels the frame |
| bit_stb | input | 1 | Serializer sent a bit in this cycle |
| bit_idx | input | POS_W | 1-based position of that bit within the character |
| frame_fmt | input | 2 | Format code: 0 parity-8, 1 plain-8, 2 x-bit, 3 as code 0 |
| part_bits | input | POS_W | Character length x for format code 2 |
| fifo_empty | input | 1 | FIFO holds no byte |
| accept | output | 1 | Serializer may fetch further bytes |
| eof | output | 1 | One-cycle end-of-frame pulse |

## Verification
Both outputs are decoded from the state register. Each therefore answers one clock edge after the input that moved it: `accept` rises on the edge that captures `start` and falls on the edge that captures an empty test strobe. `eof` is high during the cycle after the edge that captures the last-bit strobe. Inputs change on falling edges, the behavioural reference steps on rising edges, and the outputs are compared with it on every falling edge. The scenario checks read the outputs after the strobe cycle and one idle cycle have passed.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam int DATA_BITS = 8;

    typedef enum logic [1:0] {
        FMT_PAR8 = 2'd0,
        FMT_RAW8 = 2'd1,
        FMT_PART = 2'd2,
        FMT_RSV  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_DRAIN,
        S_DONE
    } state_e;
endpackage

// File: rtl/txc_pos_decode.sv
module txc_pos_decode
    import txc_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic [1:0]       fmt,
    input  logic [POS_W-1:0] part_bits,
    output logic [POS_W-1:0] chk_pos,
    output logic [POS_W-1:0] last_pos
);
    localparam logic [POS_W-1:0] WORD = POS_W'(DATA_BITS);
    localparam logic [POS_W-1:0] ONE  = POS_W'(1);

    logic [POS_W-1:0] x_eff;

    // clamp the partial length into 1..WORD
    always_comb begin
        if (part_bits == '0)
            x_eff = ONE;
        else if (part_bits > WORD)
            x_eff = WORD;
        else
            x_eff = part_bits;
    end

    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_RAW8: begin
                chk_pos  = WORD - ONE;
                last_pos = WORD;
            end
            FMT_PART: begin
                chk_pos  = (x_eff == ONE) ? ONE : x_eff - ONE;
                last_pos = x_eff;
            end
            FMT_PAR8, FMT_RSV: begin
                chk_pos  = WORD;
                last_pos = WORD + ONE;
            end
        endcase
    end
endmodule

// File: rtl/txc_fsm.sv
module txc_fsm
    import txc_pkg::*;
#(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             bit_stb,
    input  logic [POS_W-1:0] bit_idx,
    input  logic [POS_W-1:0] chk_pos,
    input  logic [POS_W-1:0] last_pos,
    input  logic             fifo_empty,
    output logic             accept,
    output logic             eof
);
    state_e state_q, state_d;
    logic   at_chk, at_last;

    assign at_chk  = bit_stb && (bit_idx == chk_pos);
    assign at_last = bit_stb && (bit_idx == last_pos);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start)
                    state_d = S_RUN;
            end
            S_RUN: begin
                if (at_chk && fifo_empty)
                    state_d = (chk_pos == last_pos) ? S_DONE : S_DRAIN;
            end
            S_DRAIN: begin
                if (at_last)
                    state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
        endcase
        if (abort)
            state_d = S_IDLE;
    end

    always_comb begin
        accept = (state_q == S_RUN);
        eof    = (state_q == S_DONE);
    end
endmodule

// File: rtl/txc_frame_cont.sv
module txc_frame_cont #(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             bit_stb,
    input  logic [POS_W-1:0] bit_idx,
    input  logic [1:0]       frame_fmt,
    input  logic [POS_W-1:0] part_bits,
    input  logic             fifo_empty,
    output logic             accept,
    output logic             eof
);
    logic [POS_W-1:0] chk_pos;
    logic [POS_W-1:0] last_pos;

    txc_pos_decode #(.POS_W(POS_W)) u_dec (
        .fmt       (frame_fmt),
        .part_bits (part_bits),
        .chk_pos   (chk_pos),
        .last_pos  (last_pos)
    );

    txc_fsm #(.POS_W(POS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .abort      (abort),
        .bit_stb    (bit_stb),
        .bit_idx    (bit_idx),
        .chk_pos    (chk_pos),
        .last_pos   (last_pos),
        .fifo_empty (fifo_empty),
        .accept     (accept),
        .eof        (eof)
    );
endmodule

// File: rtl/txc_frame_cont_chk.sv
module txc_frame_cont_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic abort,
    input logic bit_stb,
    input logic fifo_empty,
    input logic accept,
    input logic eof
);
    p_rise_by_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept) |-> $past(start));

    p_fall_by_test_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(accept) |-> ($past(abort) || $past(bit_stb && fifo_empty)));

    p_keep_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bit_stb && !fifo_empty && !abort) |=> accept);

    p_eof_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof);

    p_eof_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eof) |-> $past(bit_stb));

    p_eof_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> !accept);

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!accept && !eof));
endmodule

bind txc_frame_cont txc_frame_cont_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort      (abort),
    .bit_stb    (bit_stb),
    .fifo_empty (fifo_empty),
    .accept     (accept),
    .eof        (eof)
);

// File: tb/test_txc_frame_cont.sv
module test_txc_frame_cont;
    localparam int CLK_PERIOD = 10;
    localparam int POS_W      = 4;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             abort = 1'b0;
    logic             bit_stb = 1'b0;
    logic [POS_W-1:0] bit_idx = '0;
    logic [1:0]       frame_fmt = 2'd0;
    logic [POS_W-1:0] part_bits = '0;
    logic             fifo_empty = 1'b0;
    logic             accept;
    logic             eof;

    int total = 0;
    int bad = 0;
    int eof_cnt = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    bit m_acc = 1'b0;
    bit m_drn = 1'b0;
    bit m_eof = 1'b0;

    txc_frame_cont #(.POS_W(POS_W)) i_txc_frame_cont (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .bit_stb(bit_stb), .bit_idx(bit_idx), .frame_fmt(frame_fmt),
        .part_bits(part_bits), .fifo_empty(fifo_empty),
        .accept(accept), .eof(eof)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // test position and last bit taken from the requirements
    function automatic void positions(output int c, output int l);
        int x;
        x = int'(part_bits);
        if (x < 1) x = 1;
        if (x > 8) x = 8;
        case (frame_fmt)
            2'd1:    begin c = 7; l = 8; end
            2'd2:    begin c = (x == 1) ? 1 : x - 1; l = x; end
            default: begin c = 8; l = 9; end
        endcase
    endfunction

    always @(posedge clk) begin
        int c, l;
        bit nxt_eof;
        positions(c, l);
        nxt_eof = 1'b0;
        if (!rst_n) begin
            m_acc = 0; m_drn = 0;
        end else if (abort) begin
            m_acc = 0; m_drn = 0;
        end else if (!m_acc && !m_drn && !m_eof) begin
            if (start) m_acc = 1;
        end else if (m_acc) begin
            if (bit_stb && int'(bit_idx) == c && fifo_empty) begin
                m_acc = 0;
                if (c == l) nxt_eof = 1; else m_drn = 1;
            end
        end else if (m_drn) begin
            if (bit_stb && int'(bit_idx) == l) begin
                m_drn = 0; nxt_eof = 1;
            end
        end
        m_eof = nxt_eof;
    end

    always @(negedge clk) begin
        cycles++;
        if (eof === 1'b1) eof_cnt++;
        check("R2 accept vs model", int'(accept), int'(m_acc));
        check("R8 eof vs model", int'(eof), int'(m_eof));
        if (cycles > WATCHDOG) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_up();
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    endtask

    task automatic send_bit(int pos, bit emp);
        bit_stb = 1'b1; bit_idx = POS_W'(pos); fifo_empty = emp;
        @(negedge clk);
        bit_stb = 1'b0; fifo_empty = 1'b0;
        @(negedge clk);
    endtask

    // send positions lo..hi with FIFO empty only at position emp_at (0: never)
    task automatic send_run(int lo, int hi, int emp_at);
        for (int p = lo; p <= hi; p++) send_bit(p, p == emp_at);
    endtask

    initial begin
        int e0;
        idle(2);
        check("R10 accept in reset", int'(accept), 0);
        check("R10 eof in reset", int'(eof), 0);
        rst_n = 1'b1;
        idle(1);

        // R3: parity format, empty everywhere except bit 8 -> continues
        frame_fmt = 2'd0;
        pulse_start();
        check("R1 accept after start", int'(accept), 1);
        for (int p = 1; p <= 9; p++) send_bit(p, p != 8);
        check("R2 empty off test position ignored", int'(accept), 1);
        e0 = eof_cnt;
        send_run(1, 7, 0);
        send_bit(8, 1'b1);
        check("R3 accept drops at bit 8", int'(accept), 0);
        check("R8 no eof before last bit", eof_cnt - e0, 0);
        pulse_start();
        check("R1 start ignored while draining", int'(accept), 0);
        send_bit(9, 1'b0);
        check("R8 eof after last bit", eof_cnt - e0, 1);

        // R7: long frame continues well beyond a FIFO depth
        pulse_start();
        for (int k = 0; k < 70; k++) send_run(1, 9, 0);
        check("R7 long frame keeps accept", int'(accept), 1);
        e0 = eof_cnt;
        send_run(1, 9, 8);
        check("R7 long frame ends once", eof_cnt - e0, 1);

        // R4: plain 8-bit, empty at bit 8 ignored, empty at 7 ends
        frame_fmt = 2'd1;
        pulse_start();
        send_run(1, 8, 8);
        check("R4 bit 8 is not the test", int'(accept), 1);
        e0 = eof_cnt;
        send_run(1, 7, 7);
        check("R4 accept drops at bit 7", int'(accept), 0);
        send_bit(8, 1'b0);
        check("R4 eof after bit 8", eof_cnt - e0, 1);

        // R5: x-bit, x=5 tests at 4
        frame_fmt = 2'd2; part_bits = 4'd5;
        pulse_start();
        send_run(1, 5, 5);
        check("R5 bit 5 is not the test", int'(accept), 1);
        e0 = eof_cnt;
        send_run(1, 4, 4);
        check("R5 accept drops at bit 4", int'(accept), 0);
        send_bit(5, 1'b0);
        check("R5 eof after bit 5", eof_cnt - e0, 1);

        // R6: x=1 tests and ends at bit 1; x=0 clamps to 1
        part_bits = 4'd1;
        pulse_start();
        send_bit(1, 1'b0);
        check("R6 x=1 full keeps accept", int'(accept), 1);
        e0 = eof_cnt;
        send_bit(1, 1'b1);
        check("R6 x=1 eof at once", eof_cnt - e0, 1);
        part_bits = 4'd0;
        pulse_start();
        e0 = eof_cnt;
        send_bit(1, 1'b1);
        check("R6 x=0 acts as 1", eof_cnt - e0, 1);
        part_bits = 4'd12;
        pulse_start();
        send_bit(8, 1'b1);
        check("R6 x=12 clamps, bit 8 not test", int'(accept), 1);
        e0 = eof_cnt;
        send_run(1, 8, 7);
        check("R6 x=12 ends like x=8", eof_cnt - e0, 1);

        // R3: code 3 follows code 0
        frame_fmt = 2'd3;
        pulse_start();
        send_bit(7, 1'b1);
        check("R3 code 3 bit 7 not test", int'(accept), 1);
        send_bit(8, 1'b1);
        check("R3 code 3 drops at bit 8", int'(accept), 0);
        send_bit(9, 1'b0);

        // R9: abort in drain gives no eof; abort beats start
        frame_fmt = 2'd1;
        pulse_start();
        send_run(1, 7, 7);
        e0 = eof_cnt;
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        send_bit(8, 1'b0);
        check("R9 abort suppresses eof", eof_cnt - e0, 0);
        start = 1'b1; abort = 1'b1; @(negedge clk);
        start = 1'b0; abort = 1'b0; @(negedge clk);
        check("R9 abort wins over start", int'(accept), 0);
        pulse_start();
        abort = 1'b1; @(negedge clk); abort = 1'b0; @(negedge clk);
        check("R9 abort clears accept", int'(accept), 0);

        // R10: reset mid-frame
        pulse_start();
        rst_n = 1'b0; @(negedge clk);
        check("R10 reset clears accept", int'(accept), 0);
        rst_n = 1'b1;
        idle(2);
        finish_up();
    end
endmodule